// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

A four-bit reversible counter. All state bits change together on the rising clock edge. A build-time parameter sets the modulus: plain binary counting from 0 to 15, or decimal counting from 0 to 9. An active-low enable gates counting, and a direction input picks up or down.

An active-low load input forces the count to the data word as soon as it goes low. The load does not wait for the clock, so the counter can serve as a divide-by-N stage by presetting its start value.

Two outputs support chaining.
- The terminal flag is high while the count sits at the end of its range for the present direction.
- The active-low ripple output repeats that condition, but only during the low half of the clock and only while counting is enabled. A following stage can use it as its enable or as its clock.

Top module: `updown_preset_counter`

## Requirements
- R1: The count changes only on a rising clock edge, apart from the load. The ripple output is high whenever the clock is high.
- R2: While `cnt_en_n` is 1, clock edges leave the count unchanged.
- R3: With `cnt_en_n` at 0, `dir_down` = 0 adds one per rising edge and `dir_down` = 1 subtracts one per rising edge.
- R4: While `load_n` is 0, `count` equals `din` at once, without waiting for a clock edge.
- R5: Load has priority over counting. While `load_n` is 0, clock edges leave the count at `din` whatever the enable and direction inputs are.
- R6: With `DECIMAL` = 0, the count wraps modulo 16: 15 counting up gives 0, and 0 counting down gives 15.
- R7: With `DECIMAL` = 1, 9 counting up gives 0 and 0 counting down gives 9. Once counting starts from a legal value, the count never leaves the range 0 to 9.
- R8: With `DECIMAL` = 1, a loaded value from 10 to 15 goes to 0 on an up count and to the value minus one on a down count.
- R9: `term_flag` is 1 exactly when the count equals the top value (15 binary, 9 decimal) with `dir_down` = 0, or equals 0 with `dir_down` = 1.
- R10: `ripple_n` is 0 exactly when `term_flag` is 1, `cnt_en_n` is 0 and `clk` is 0. At all other times it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous preset, active low |
| din | input | 4 | Preset value |
| count | output | 4 | Present count |
| term_flag | output | 1 | Terminal count reached for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse during the low clock phase |

## Verification
The bench builds two copies side by side, one with `DECIMAL` = 0 and one with `DECIMAL` = 1, and drives both from the same inputs. The binary copy brings the modulo-16 wrap in both directions within reach. The decimal copy brings the 9/0 turnarounds and the recovery from loaded values 10 to 15 within reach. Enable and direction change only while the clock is high. Sampling in the low phase exposes the ripple pulse. A load dropped between edges exposes the asynchronous preset.

// File: rtl/upc_pkg.sv
package upc_pkg;

  localparam int unsigned UPC_W = 4;

  typedef logic [UPC_W-1:0] upc_val_t;

  // highest value reached before wrapping
  function automatic upc_val_t upc_top(input bit decimal);
    return decimal ? upc_val_t'(9) : upc_val_t'(15);
  endfunction

  // next value for one enabled count step
  function automatic upc_val_t upc_step(input upc_val_t cur, input logic down,
                                        input bit decimal);
    upc_val_t res;
    if (!down) begin
      if (cur >= upc_top(decimal)) res = '0;
      else                         res = cur + upc_val_t'(1);
    end else begin
      if (cur == '0) res = upc_top(decimal);
      else           res = cur - upc_val_t'(1);
    end
    return res;
  endfunction

  // end-of-range detection for the present direction
  function automatic logic upc_at_end(input upc_val_t cur, input logic down,
                                      input bit decimal);
    return down ? (cur == '0) : (cur == upc_top(decimal));
  endfunction

endpackage

// File: rtl/upc_next_state.sv
module upc_next_state
  import upc_pkg::*;
#(
  parameter bit DECIMAL = 1'b0
) (
  input  upc_val_t cur,
  input  logic     step_en,
  input  logic     down,
  output upc_val_t nxt
);
  always_comb begin
    if (step_en) nxt = upc_step(cur, down, DECIMAL);
    else         nxt = cur;
  end
endmodule

// File: rtl/upc_state_reg.sv
module upc_state_reg
  import upc_pkg::*;
(
  input  logic     clk,
  input  logic     load_n,
  input  upc_val_t preset,
  input  upc_val_t nxt,
  output upc_val_t q
);
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) q <= preset;
    else         q <= nxt;
  end
endmodule

// File: rtl/upc_terminal.sv
module upc_terminal
  import upc_pkg::*;
#(
  parameter bit DECIMAL = 1'b0
) (
  input  logic     clk,
  input  upc_val_t cur,
  input  logic     down,
  input  logic     cnt_active,
  output logic     at_end,
  output logic     ripple_low
);
  always_comb begin
    at_end     = upc_at_end(cur, down, DECIMAL);
    ripple_low = at_end & cnt_active & ~clk;
  end
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
  import upc_pkg::*;
#(
  parameter bit DECIMAL = 1'b0
) (
  input  logic             clk,
  input  logic             cnt_en_n,
  input  logic             dir_down,
  input  logic             load_n,
  input  logic [UPC_W-1:0] din,
  output logic [UPC_W-1:0] count,
  output logic             term_flag,
  output logic             ripple_n
);
  localparam upc_val_t TOP_VAL = upc_top(DECIMAL);

  // named internal events, visible to the assertions
  upc_val_t q_state;
  upc_val_t nxt_state;
  logic     cnt_active;
  logic     end_hit;
  logic     ripple_low;

  assign cnt_active = ~cnt_en_n;

  upc_next_state #(.DECIMAL(DECIMAL)) u_next (
    .cur     (q_state),
    .step_en (cnt_active),
    .down    (dir_down),
    .nxt     (nxt_state)
  );

  upc_state_reg u_reg (
    .clk    (clk),
    .load_n (load_n),
    .preset (din),
    .nxt    (nxt_state),
    .q      (q_state)
  );

  // a held load passes the data word straight through
  assign count = load_n ? q_state : din;

  upc_terminal #(.DECIMAL(DECIMAL)) u_term (
    .clk        (clk),
    .cur        (count),
    .down       (dir_down),
    .cnt_active (cnt_active),
    .at_end     (end_hit),
    .ripple_low (ripple_low)
  );

  assign term_flag = end_hit;
  assign ripple_n  = ~ripple_low;

  // R2: a disabled edge keeps the count
  a_r2_hold: assert property (@(posedge clk) disable iff (!load_n)
    (cnt_en_n && load_n) |=> (count == $past(count)));

  // R3: an enabled edge always moves the count
  a_r3_moves: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && load_n) |=> (count != $past(count)));

  // R7: a decimal count started from a legal value stays legal
  a_r7_bcd_range: assert property (@(posedge clk) disable iff (!load_n)
    (DECIMAL && !cnt_en_n && load_n && count <= TOP_VAL) |=> (count <= TOP_VAL));

  // R9: the flag appears only at the two ends of the range
  a_r9_term_ends: assert property (@(posedge clk)
    term_flag |-> (count == '0 || count == TOP_VAL));

  // R10: no ripple pulse while counting is disabled or the clock is high
  always_comb begin
    a_r10_ripple_gate: assert (!(!ripple_n && (cnt_en_n || clk)));
  end

endmodule

// File: tb/updown_preset_counter_tb.sv
module updown_preset_counter_tb;
  logic       clk = 1'b0;
  logic       cnt_en_n = 1'b1;
  logic       dir_down = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt_bin, cnt_dec;
  logic       tf_bin, tf_dec, rp_bin, rp_dec;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  updown_preset_counter #(.DECIMAL(1'b0)) u_dut (
    .clk(clk), .cnt_en_n(cnt_en_n), .dir_down(dir_down), .load_n(load_n),
    .din(din), .count(cnt_bin), .term_flag(tf_bin), .ripple_n(rp_bin));

  updown_preset_counter #(.DECIMAL(1'b1)) u_dut_dec (
    .clk(clk), .cnt_en_n(cnt_en_n), .dir_down(dir_down), .load_n(load_n),
    .din(din), .count(cnt_dec), .term_flag(tf_dec), .ripple_n(rp_dec));

  // {load_n, cnt_en_n, dir_down, din, expected count, expected flag}
  localparam logic [11:0] VEC [12] = '{
    {1'b0, 1'b1, 1'b0, 4'd14, 4'd14, 1'b0},
    {1'b1, 1'b0, 1'b0, 4'd0,  4'd15, 1'b1},
    {1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
    {1'b1, 1'b0, 1'b0, 4'd0,  4'd1,  1'b0},
    {1'b1, 1'b1, 1'b0, 4'd0,  4'd1,  1'b0},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  1'b1},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b0},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd14, 1'b0},
    {1'b0, 1'b1, 1'b1, 4'd3,  4'd3,  1'b0},
    {1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0},
    {1'b1, 1'b0, 1'b0, 4'd0,  4'd8,  1'b0},
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // entered 1 ns after a rising edge; drive in the high phase, check after the next edge
  task automatic step(input logic ld, input logic en, input logic dn, input logic [3:0] d);
    #1;
    load_n = ld; cnt_en_n = en; dir_down = dn; din = d;
    @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk); #1;

    // table walk on the binary copy: R1 R2 R3 R5 R6 R9
    foreach (VEC[i]) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      check("R6/R3 binary count", cnt_bin, VEC[i][4:1]);
      check("R9 binary flag", tf_bin, VEC[i][0]);
    end

    // decimal copy, directed
    step(1'b0, 1'b1, 1'b0, 4'd8);
    check("R4 load 8", cnt_dec, 8);
    step(1'b1, 1'b0, 1'b0, 4'd0);
    check("R3 up to 9", cnt_dec, 9);
    check("R9 flag at 9 up", tf_dec, 1);
    check("R1 ripple high while clk high", rp_dec, 1);
    #5;
    check("R10 ripple low in low phase", rp_dec, 0);
    @(posedge clk); #1;
    check("R7 9 up wraps to 0", cnt_dec, 0);
    step(1'b1, 1'b0, 1'b1, 4'd0);
    check("R7 0 down wraps to 9", cnt_dec, 9);
    check("R9 no flag at 9 down", tf_dec, 0);
    step(1'b0, 1'b1, 1'b0, 4'd12);
    check("R4 load 12", cnt_dec, 12);
    step(1'b1, 1'b0, 1'b0, 4'd12);
    check("R8 12 up gives 0", cnt_dec, 0);
    step(1'b0, 1'b1, 1'b1, 4'd12);
    step(1'b1, 1'b0, 1'b1, 4'd12);
    check("R8 12 down gives 11", cnt_dec, 11);
    step(1'b0, 1'b1, 1'b1, 4'd0);
    check("R9 flag at 0 down", tf_dec, 1);
    #5;
    check("R10 ripple high while disabled", rp_dec, 1);
    @(posedge clk); #1;
    check("R5 load holds across edge", cnt_dec, 0);
    step(1'b1, 1'b0, 1'b1, 4'd0);
    check("R7 0 down gives 9", cnt_dec, 9);
    step(1'b1, 1'b1, 1'b1, 4'd0);
    check("R2 hold while disabled", cnt_dec, 9);

    // load dropped between edges
    #2;
    din = 4'd5; load_n = 1'b0;
    #1;
    check("R4 async load decimal", cnt_dec, 5);
    check("R4 async load binary", cnt_bin, 5);
    @(posedge clk); #1;
    step(1'b1, 1'b0, 1'b1, 4'd5);
    check("R3 down from 5", cnt_dec, 4);
    check("R3 binary down from 5", cnt_bin, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule